// File: doc/BRIEF.md
# GPIO Bank Output Data and Direction Register

This block keeps the output state of a single bank of general-purpose pins. It holds three things for each pin: the value the pin drives, a direction bit and an output-enable bit. From these it produces the pad output values and the pad tri-state enables. It also returns the pad input values, synchronised to the local clock, when software reads the bank.

Software can set all output values with a single full-word write. It can also change any subset of pins without a read-modify-write. For that it uses two half-word masked registers: one for the lower half of the bank and one for the upper half. In a masked write, the upper half of the word is an active-low mask and the lower half is the new data. A pin whose mask bit is 0 takes the matching data bit. A pin whose mask bit is 1 keeps its current value. Interrupt logic and the bus protocol sit outside this block. Requests arrive as a single-cycle write strobe with an address and a data word, and read data is returned combinationally from the address.

Top module: `gpio_bank_out`

## Requirements
- R1: After reset the output data, direction and output-enable registers are all 0, pad_out_o is 0 and pad_oe_o is 0.
- R2: A write to address 0 (full data) replaces every output bit with the written word. The new value appears on pad_out_o after the clock edge that takes the write, and no earlier value survives.
- R3: A write to address 1 (masked low) updates pins 0 to 15. Word bits 31:16 are the mask for pins 0 to 15, and bits 15:0 are their data. A pin whose mask bit is 0 takes its data bit. A pin whose mask bit is 1 keeps its value. Pins 16 to 31 are not changed.
- R4: A write to address 2 (masked high) updates pins 16 to 31. Word bit 16+k is the mask for pin 16+k and word bit k is its data, for k from 0 to 15. The same mask rule as R3 applies, and pins 0 to 15 are not changed.
- R5: A write to address 3 stores the direction word, where 1 means output and 0 means input. Reading address 3 returns the stored word.
- R6: A write to address 4 stores the output-enable word, where 1 means enabled. Reading address 4 returns the stored word.
- R7: pad_oe_o bit n is 1 only when both direction bit n and output-enable bit n are 1.
- R8: pad_out_o always equals the output data register, whatever the direction and output-enable settings are.
- R9: Reading address 0 returns the pad input values. A change on pad_in_i appears in the read data after exactly SYNC_STAGES rising clock edges.
- R10: Reading address 1 or address 2 returns 0 in bits 31:16 and, in bits 15:0, the current output values of the pins that register covers.
- R11: Writes to addresses 5 to 7 change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Read data for addr_i, combinational |
| pad_in_i | input | NUM_PINS | Asynchronous pad input values |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables, active high |

## Verification
The bench builds the block with NUM_PINS=32 and SYNC_STAGES=2. These are the sizes at which the half-word mask split at pin 16 and the two-edge input latency are both visible at the ports. With these values, masked writes can be checked right at the boundary between the two halves (pins 15 and 16), and the read of pad input can be sampled one edge before and at the edge where the new value becomes visible.

// File: rtl/gpio_out_pkg.sv
package gpio_out_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FULL    = 3'd0,
    SEL_MASK_LO = 3'd1,
    SEL_MASK_HI = 3'd2,
    SEL_DIR     = 3'd3,
    SEL_OUT_EN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

  // R5
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i));
  // R11
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_full_i,
  input  logic         we_lo_i,
  input  logic         we_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned HALF = W / 2;

  logic [1:0]      we_half;
  logic [HALF-1:0] mask_n, bits;
  logic [W-1:0]    nxt;

  assign we_half = {we_hi_i, we_lo_i};
  assign mask_n  = wdata_i[W-1:HALF];
  assign bits    = wdata_i[HALF-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF-1:0] cur;
    assign cur = q_o[h*HALF +: HALF];
    always_comb begin
      if (we_full_i)       nxt[h*HALF +: HALF] = wdata_i[h*HALF +: HALF];
      else if (we_half[h]) nxt[h*HALF +: HALF] = (cur & mask_n) | (bits & ~mask_n);
      else                 nxt[h*HALF +: HALF] = cur;
    end

    // R3 R4: masked pins keep their value
    mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_half[h] && !we_full_i) |=>
        ((q_o[h*HALF +: HALF] ^ $past(q_o[h*HALF +: HALF])) & $past(mask_n)) == '0);
    // R3 R4: unmasked pins take the data bit
    mask_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_half[h] && !we_full_i) |=>
        ((q_o[h*HALF +: HALF] ^ $past(bits)) & ~$past(mask_n)) == '0);
    // R3 R4: other half untouched
    half_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_full_i && !we_half[h]) |=> $stable(q_o[h*HALF +: HALF]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else q_o <= nxt;
  end

  // R2
  full_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_full_i |=> q_o == $past(wdata_i));
endmodule

// File: rtl/gpio_bank_out.sv
module gpio_bank_out
  import gpio_out_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  localparam int unsigned HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] out_q, dir_q, oen_q, pin_sync;
  logic we_full, we_lo, we_hi, we_dir, we_oen;

  assign we_full = we_i && (addr_i == SEL_FULL);
  assign we_lo   = we_i && (addr_i == SEL_MASK_LO);
  assign we_hi   = we_i && (addr_i == SEL_MASK_HI);
  assign we_dir  = we_i && (addr_i == SEL_DIR);
  assign we_oen  = we_i && (addr_i == SEL_OUT_EN);

  gpio_out_data #(.W(NUM_PINS)) u_data (
    .clk_i, .rst_ni,
    .we_full_i (we_full),
    .we_lo_i   (we_lo),
    .we_hi_i   (we_hi),
    .wdata_i,
    .q_o       (out_q)
  );

  gpio_ctrl_reg #(.W(NUM_PINS)) u_dir (
    .clk_i, .rst_ni, .we_i(we_dir), .wdata_i, .q_o(dir_q)
  );

  gpio_ctrl_reg #(.W(NUM_PINS)) u_oen (
    .clk_i, .rst_ni, .we_i(we_oen), .wdata_i, .q_o(oen_q)
  );

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin_sync)
  );

  always_comb begin
    unique case (addr_i)
      SEL_FULL:    rdata_o = pin_sync;
      SEL_MASK_LO: rdata_o = {{HALF{1'b0}}, out_q[HALF-1:0]};
      SEL_MASK_HI: rdata_o = {{HALF{1'b0}}, out_q[NUM_PINS-1:HALF]};
      SEL_DIR:     rdata_o = dir_q;
      SEL_OUT_EN:  rdata_o = oen_q;
      default:     rdata_o = '0;
    endcase
  end

  assign pad_out_o = out_q;
  assign pad_oe_o  = dir_q & oen_q;

  // R7
  oe_needs_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~dir_q) == '0);
  // R7
  oe_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~oen_q) == '0);
  // R10
  mask_rd_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SEL_MASK_LO || addr_i == SEL_MASK_HI) |-> rdata_o[NUM_PINS-1:HALF] == '0);
  // R11
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > SEL_OUT_EN) |-> rdata_o == '0);
endmodule

// File: tb/tb_gpio_bank_out.sv
module tb_gpio_bank_out;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [W-1:0]  wdata_i = '0;
  logic [W-1:0]  rdata_o, pad_in_i, pad_out_o, pad_oe_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_out = '0, exp_dir = '0, exp_oen = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_out #(.NUM_PINS(W), .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pad_in_i, .pad_out_o, .pad_oe_o
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  function automatic logic [15:0] mmerge(input logic [15:0] cur, input logic [W-1:0] w);
    return (cur & w[31:16]) | (w[15:0] & ~w[31:16]);
  endfunction

  task automatic t_reset();
    logic [W-1:0] r;
    check("R1 pad_out", pad_out_o, '0);
    check("R1 pad_oe", pad_oe_o, '0);
    rd(3'd3, r); check("R1 dir", r, '0);
    rd(3'd4, r); check("R1 oe", r, '0);
    rd(3'd1, r); check("R1 data lo", r, '0);
  endtask

  task automatic t_full_write();
    wr(3'd0, 32'hDEAD_BEEF); exp_out = 32'hDEAD_BEEF;
    check("R2 first", pad_out_o, exp_out);
    wr(3'd0, 32'h0000_0001); exp_out = 32'h0000_0001;
    check("R2 replace", pad_out_o, exp_out);
  endtask

  task automatic t_masked_lo();
    logic [W-1:0] r;
    wr(3'd0, 32'hA5A5_5A5A); exp_out = 32'hA5A5_5A5A;
    wr(3'd1, 32'h7FFE_8001); exp_out[15:0] = mmerge(exp_out[15:0], 32'h7FFE_8001);
    check("R3 edge bits", pad_out_o, exp_out);
    wr(3'd1, 32'hFFFF_0000);
    check("R3 all masked", pad_out_o, exp_out);
    wr(3'd1, 32'h0000_1234); exp_out[15:0] = 16'h1234;
    check("R3 all open", pad_out_o, exp_out);
    rd(3'd1, r); check("R10 lo read", r, {16'h0, exp_out[15:0]});
  endtask

  task automatic t_masked_hi();
    logic [W-1:0] r;
    wr(3'd2, 32'hFFFE_FFFF); exp_out[31:16] = mmerge(exp_out[31:16], 32'hFFFE_FFFF);
    check("R4 pin16", pad_out_o, exp_out);
    wr(3'd2, 32'h00FF_ABCD); exp_out[31:16] = mmerge(exp_out[31:16], 32'h00FF_ABCD);
    check("R4 mixed", pad_out_o, exp_out);
    rd(3'd2, r); check("R10 hi read", r, {16'h0, exp_out[31:16]});
  endtask

  task automatic t_dir_oe();
    logic [W-1:0] r;
    wr(3'd3, 32'hF0F0_FF00); exp_dir = 32'hF0F0_FF00;
    rd(3'd3, r); check("R5 dir read", r, exp_dir);
    check("R7 dir only", pad_oe_o, '0);
    wr(3'd4, 32'hCCCC_0FF0); exp_oen = 32'hCCCC_0FF0;
    rd(3'd4, r); check("R6 oe read", r, exp_oen);
    check("R7 both", pad_oe_o, exp_dir & exp_oen);
    check("R8 out indep", pad_out_o, exp_out);
  endtask

  task automatic t_pad_in();
    logic [W-1:0] r;
    @(negedge clk);
    pad_in_i = 32'h1357_9BDF;
    @(negedge clk);
    rd(3'd0, r); check("R9 one edge", r, '0);
    @(negedge clk);
    rd(3'd0, r); check("R9 two edges", r, 32'h1357_9BDF);
  endtask

  task automatic t_unmapped();
    logic [W-1:0] r;
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), r); check("R11 rd zero", r, '0);
    end
    check("R11 data", pad_out_o, exp_out);
    rd(3'd3, r); check("R11 dir", r, exp_dir);
    rd(3'd4, r); check("R11 oe", r, exp_oen);
  endtask

  initial begin
    pad_in_i = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_full_write();
    t_masked_lo();
    t_masked_hi();
    t_dir_oe();
    t_pad_in();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule